// File: doc/BRIEF.md
# SHA-512 Operation Decoder

This block sits in the decode stage of a processor that supports hardware assistance for SHA-512 hashing. It looks at one 32-bit instruction word and decides whether the word belongs to the SHA-512 vector group. The group has two encodings: a three-register form and a two-register form.

For a recognised word, the block returns the destination and source register indices and a one-hot code that names the operation. It also returns one verdict: execute, undefined instruction, or access trap. Two inputs steer the verdict. One enables the SHA-512 feature. The other reports whether floating-point/SIMD register access is currently permitted. A word outside both forms gets a separate no-match verdict, so the surrounding decoder can try its other groups.

The result is captured on a decode strobe and appears one clock later.

Top module: `sha512_op_decoder`

## Requirements
- R1: While `rst` is high at a rising clock edge, all outputs are cleared to zero on that edge (`out_valid`, `out_result`, `out_op`, `out_rd`, `out_rn`, `out_rm`).
- R2: A word presented with `in_valid` high at a rising edge produces its result, with `out_valid` high, after that edge. A rising edge with `in_valid` low drops `out_valid` and leaves the other outputs unchanged.
- R3: A word satisfies the three-register form when `(insn & 32'hFFE0B000) == 32'hCE608000`. For such a word, `out_rm` = bits 20:16, `out_rn` = bits 9:5 and `out_rd` = bits 4:0.
- R4: In the three-register form with bit 14 clear, bits 11:10 select the operation as follows: 0 is round part one (`out_op` bit 0), 1 is round part two (bit 1), 2 is message-schedule sigma1 (bit 2). The value 3 is undefined.
- R5: A three-register word with bit 14 set is undefined for every value of bits 11:10.
- R6: A word satisfies the two-register form when `(insn & 32'hFFFFF000) == 32'hCEC08000`. In this form bits 11:10 = 0 selects message-schedule sigma0 (`out_op` bit 3), and any other value is undefined. `out_rn` = bits 9:5, `out_rd` = bits 4:0, and `out_rm` = 0.
- R7: A word that satisfies neither form gets `out_result` = 2'b00 (no match), with `out_op`, `out_rd`, `out_rn` and `out_rm` all zero.
- R8: When `sha512_en` is low, every word that satisfies either form gets `out_result` = 2'b10 (undefined), whatever the value of `simd_access_ok`.
- R9: The verdict is chosen in this order. An undefined verdict (2'b10) takes precedence over a trap. A trap (2'b11) is given only when the word is a defined operation, the feature is enabled, and `simd_access_ok` is low. Otherwise the verdict is execute (2'b01).
- R10: `out_op` is one-hot for the execute and trap verdicts and is zero for the undefined and no-match verdicts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decode strobe for `insn_word` |
| insn_word | input | 32 | Instruction word to classify |
| sha512_en | input | 1 | SHA-512 feature enabled |
| simd_access_ok | input | 1 | Floating-point/SIMD access permitted |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | 2 | Verdict: 00 no match, 01 execute, 10 undefined, 11 trap |
| out_op | output | 4 | One-hot operation: bit0 round part one, bit1 round part two, bit2 sigma1 schedule, bit3 sigma0 schedule |
| out_rd | output | 5 | Destination register index |
| out_rn | output | 5 | First source register index |
| out_rm | output | 5 | Second source register index (zero for the two-register form) |

## Verification
The bench drives every combination of the selector bits in both forms: bit 14 and bits 11:10 for the three-register form, bits 11:10 for the two-register form. Each combination is run under all four settings of the feature and access inputs. This separates the execute, undefined and trap verdicts and shows that undefined wins over trap. Near-miss words are also applied, each with one fixed bit flipped, along with an all-zero word. These show that a no-match is reported apart from an undefined verdict. Random register fields, idle cycles between words and a reset in the middle of the run show that the indices go to the correct outputs and that the outputs hold between strobes.

// File: rtl/sha512_dec_pkg.sv
package sha512_dec_pkg;
  typedef enum logic [1:0] {
    RES_NOMATCH = 2'b00,
    RES_EXEC    = 2'b01,
    RES_UNDEF   = 2'b10,
    RES_TRAP    = 2'b11
  } dec_result_e;

  localparam int NUM_OPS  = 4;
  localparam int OP_RND1  = 0;
  localparam int OP_RND2  = 1;
  localparam int OP_SIG1  = 2;
  localparam int OP_SIG0  = 3;

  localparam int INSN_W   = 32;
  localparam logic [INSN_W-1:0] TRI_MASK = 32'hFFE0B000;
  localparam logic [INSN_W-1:0] TRI_PAT  = 32'hCE608000;
  localparam logic [INSN_W-1:0] DUO_MASK = 32'hFFFFF000;
  localparam logic [INSN_W-1:0] DUO_PAT  = 32'hCEC08000;
endpackage

// File: rtl/sha512_form_match.sv
module sha512_form_match
  import sha512_dec_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output logic              hit_tri,
  output logic              hit_duo
);
  always_comb begin
    hit_tri = (insn & TRI_MASK) == TRI_PAT;
    hit_duo = (insn & DUO_MASK) == DUO_PAT;
  end
endmodule

// File: rtl/sha512_op_select.sv
module sha512_op_select
  import sha512_dec_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic               hit_tri,
  input  logic               hit_duo,
  input  logic               o_bit,
  input  logic [SEL_W-1:0]   sel,
  output logic [NUM_OPS-1:0] op_raw,
  output logic               legal
);
  always_comb begin
    op_raw = '0;
    if (hit_tri && !o_bit) begin
      case (sel)
        SEL_W'(0): op_raw[OP_RND1] = 1'b1;
        SEL_W'(1): op_raw[OP_RND2] = 1'b1;
        SEL_W'(2): op_raw[OP_SIG1] = 1'b1;
        default:   op_raw = '0;
      endcase
    end else if (hit_duo && sel == '0) begin
      op_raw[OP_SIG0] = 1'b1;
    end
    legal = |op_raw;
  end

  always_comb begin
    // The two masks disagree on fixed bits, so a word cannot hit both forms.
    assert (!(hit_tri && hit_duo)); // R6
  end
endmodule

// File: rtl/sha512_reg_fields.sv
module sha512_reg_fields #(
  parameter int IDX_W   = 5,
  parameter int NFIELDS = 3
) (
  input  logic [NFIELDS*IDX_W-1:0] raw,
  input  logic [NFIELDS-1:0]       keep,
  output logic [NFIELDS*IDX_W-1:0] idx
);
  for (genvar g = 0; g < NFIELDS; g++) begin : g_field
    assign idx[g*IDX_W +: IDX_W] = keep[g] ? raw[g*IDX_W +: IDX_W] : '0;
  end
endmodule

// File: rtl/sha512_verdict.sv
module sha512_verdict
  import sha512_dec_pkg::*;
(
  input  logic        hit,
  input  logic        legal,
  input  logic        feat_en,
  input  logic        access_ok,
  output dec_result_e res
);
  always_comb begin
    if (!hit)                   res = RES_NOMATCH;
    else if (!legal || !feat_en) res = RES_UNDEF;
    else if (!access_ok)        res = RES_TRAP;
    else                        res = RES_EXEC;
  end
endmodule

// File: rtl/sha512_op_decoder.sv
module sha512_op_decoder
  import sha512_dec_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [31:0]        insn_word,
  input  logic               sha512_en,
  input  logic               simd_access_ok,
  output logic               out_valid,
  output logic [1:0]         out_result,
  output logic [3:0]         out_op,
  output logic [IDX_W-1:0]   out_rd,
  output logic [IDX_W-1:0]   out_rn,
  output logic [IDX_W-1:0]   out_rm
);
  localparam int NFIELDS = 3;
  localparam int RD_LSB  = 0;
  localparam int RN_LSB  = RD_LSB + IDX_W;
  localparam int RM_LSB  = 16;
  localparam int O_BIT   = 14;
  localparam int SEL_LSB = 10;
  localparam int SEL_W   = 2;

  logic               hit_tri, hit_duo, hit_any, legal;
  logic [NUM_OPS-1:0] op_raw;
  dec_result_e        res;
  logic [NFIELDS*IDX_W-1:0] idx_raw, idx_kept;
  logic [NFIELDS-1:0] keep;

  sha512_form_match u_match (
    .insn    (insn_word),
    .hit_tri (hit_tri),
    .hit_duo (hit_duo)
  );

  sha512_op_select #(.SEL_W(SEL_W)) u_sel (
    .hit_tri (hit_tri),
    .hit_duo (hit_duo),
    .o_bit   (insn_word[O_BIT]),
    .sel     (insn_word[SEL_LSB +: SEL_W]),
    .op_raw  (op_raw),
    .legal   (legal)
  );

  assign hit_any = hit_tri | hit_duo;
  assign idx_raw = {insn_word[RM_LSB +: IDX_W], insn_word[RN_LSB +: IDX_W],
                    insn_word[RD_LSB +: IDX_W]};
  assign keep    = {hit_tri, hit_any, hit_any};

  sha512_reg_fields #(.IDX_W(IDX_W), .NFIELDS(NFIELDS)) u_fields (
    .raw  (idx_raw),
    .keep (keep),
    .idx  (idx_kept)
  );

  sha512_verdict u_verdict (
    .hit       (hit_any),
    .legal     (legal),
    .feat_en   (sha512_en),
    .access_ok (simd_access_ok),
    .res       (res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= RES_NOMATCH;
      out_op     <= '0;
      out_rd     <= '0;
      out_rn     <= '0;
      out_rm     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= res;
        out_op     <= (res == RES_EXEC || res == RES_TRAP) ? op_raw : '0;
        out_rd     <= idx_kept[0*IDX_W +: IDX_W];
        out_rn     <= idx_kept[1*IDX_W +: IDX_W];
        out_rm     <= idx_kept[2*IDX_W +: IDX_W];
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(out_result) && $stable(out_op)); // R2
  AST_OP_ONE_WHEN_ISSUED: assert property (@(posedge clk) disable iff (rst)
    out_valid && (out_result == RES_EXEC || out_result == RES_TRAP)
      |-> $countones(out_op) == 1); // R10
  AST_OP_ZERO_OTHERWISE: assert property (@(posedge clk) disable iff (rst)
    out_valid && (out_result == RES_UNDEF || out_result == RES_NOMATCH)
      |-> out_op == '0); // R10
  AST_FEATURE_OFF_UNDEF: assert property (@(posedge clk) disable iff (rst)
    in_valid && !sha512_en && (hit_tri || hit_duo) |=> out_result == RES_UNDEF); // R8
  AST_TRAP_ONLY_ENABLED: assert property (@(posedge clk) disable iff (rst)
    in_valid && (!sha512_en || simd_access_ok) |=> out_result != RES_TRAP); // R9
  AST_NOMATCH_CLEAR: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_result == RES_NOMATCH
      |-> out_rd == '0 && out_rn == '0 && out_rm == '0); // R7
endmodule

// File: tb/test_sha512_op_decoder.sv
module test_sha512_op_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] insn_word;
  logic        sha512_en;
  logic        simd_access_ok;
  logic        out_valid;
  logic [1:0]  out_result;
  logic [3:0]  out_op;
  logic [4:0]  out_rd, out_rn, out_rm;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // reference state
  logic       e_valid;
  logic [1:0] e_res;
  logic [3:0] e_op;
  logic [4:0] e_rd, e_rn, e_rm;
  string      e_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  sha512_op_decoder i_sha512_op_decoder (
    .clk            (clk),
    .rst            (rst),
    .in_valid       (in_valid),
    .insn_word      (insn_word),
    .sha512_en      (sha512_en),
    .simd_access_ok (simd_access_ok),
    .out_valid      (out_valid),
    .out_result     (out_result),
    .out_op         (out_op),
    .out_rd         (out_rd),
    .out_rn         (out_rn),
    .out_rm         (out_rm)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // behavioural model of one decode from the requirement text
  task automatic model(input logic [31:0] w, input logic fe, input logic ok);
    bit tri3, duo2, defined;
    int sel;
    logic [3:0] op;
    tri3 = (w & 32'hFFE0B000) == 32'hCE608000;
    duo2 = (w & 32'hFFFFF000) == 32'hCEC08000;
    sel = int'(w[11:10]);
    op = 4'b0;
    if (tri3 && !w[14] && sel < 3) op = 4'(1 << sel);
    if (duo2 && sel == 0) op = 4'b1000;
    defined = (op != 0);
    e_valid = 1'b1;
    if (!tri3 && !duo2) begin
      e_res = 2'b00; e_op = 0; e_rd = 0; e_rn = 0; e_rm = 0; e_tag = "R7";
    end else begin
      e_rd = w[4:0];
      e_rn = w[9:5];
      e_rm = tri3 ? w[20:16] : 5'd0;
      if (!fe) begin
        e_res = 2'b10; e_op = 0; e_tag = "R8";
      end else if (!defined) begin
        e_res = 2'b10; e_op = 0; e_tag = tri3 ? (w[14] ? "R5" : "R4") : "R6";
      end else if (!ok) begin
        e_res = 2'b11; e_op = op; e_tag = "R9";
      end else begin
        e_res = 2'b01; e_op = op; e_tag = tri3 ? "R4" : "R6";
      end
    end
  endtask

  task automatic compare_all();
    chk("R2", "out_valid", int'(out_valid), int'(e_valid));
    chk(e_tag, "out_result", int'(out_result), int'(e_res));
    chk("R10", "out_op", int'(out_op), int'(e_op));
    chk(e_tag == "R7" ? "R7" : "R3", "out_rd", int'(out_rd), int'(e_rd));
    chk(e_tag == "R7" ? "R7" : "R3", "out_rn", int'(out_rn), int'(e_rn));
    chk(e_tag == "R7" ? "R7" : "R6", "out_rm", int'(out_rm), int'(e_rm));
  endtask

  // drive at negedge, clock once, compare at the following negedge
  task automatic apply(input logic [31:0] w, input logic fe, input logic ok);
    insn_word = w; sha512_en = fe; simd_access_ok = ok; in_valid = 1'b1;
    model(w, fe, ok);
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    in_valid = 1'b0;
    insn_word = $urandom;
    e_valid = 1'b0;
    e_tag = "R2";
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b1; insn_word = 32'hCE608000;
    sha512_en = 1'b1; simd_access_ok = 1'b1;
    @(posedge clk);
    @(negedge clk);
    e_valid = 0; e_res = 0; e_op = 0; e_rd = 0; e_rn = 0; e_rm = 0; e_tag = "R1";
    compare_all();
    rst = 1'b0;
    in_valid = 1'b0;
  endtask

  function automatic logic [31:0] rnd_regs();
    logic [31:0] r;
    r = $urandom;
    return {11'b0, r[20:16], 6'b0, r[9:0]};
  endfunction

  initial begin
    @(negedge clk);
    do_reset();

    // three-register form: every O bit and selector, every enable combination
    for (int o = 0; o < 2; o++)
      for (int s = 0; s < 4; s++)
        for (int fe = 0; fe < 2; fe++)
          for (int ok = 0; ok < 2; ok++)
            apply(32'hCE608000 | rnd_regs() | (32'(o) << 14) | (32'(s) << 10),
                  fe[0], ok[0]);

    idle();
    idle();

    // two-register form
    for (int s = 0; s < 4; s++)
      for (int fe = 0; fe < 2; fe++)
        for (int ok = 0; ok < 2; ok++)
          apply(32'hCEC08000 | (rnd_regs() & 32'h3FF) | (32'(s) << 10),
                fe[0], ok[0]);

    // near misses and unrelated words -> no match (R7)
    apply(32'hCE608000 | 32'h00002000, 1'b1, 1'b1); // bit 13 set
    apply(32'hCE600000 | 32'h0000001F, 1'b1, 1'b1); // bit 15 clear
    apply(32'hCEC08000 | 32'h00001000, 1'b1, 1'b1); // bit 12 set
    apply(32'hCEC18000, 1'b1, 1'b1);                // bit 16 set in two-reg
    apply(32'h00000000, 1'b0, 1'b0);
    apply(32'hCE608000 | 32'h00010000, 1'b1, 1'b1); // tri with Rm=1

    // hold behaviour across idles, then mid-run reset
    apply(32'hCE608421, 1'b1, 1'b0);
    idle();
    idle();
    do_reset();
    idle();
    for (int k = 0; k < 40; k++) begin
      logic [31:0] r;
      r = $urandom;
      apply((r[0] ? 32'hCE608000 : 32'hCEC08000) | rnd_regs() | (32'(r[3:1]) << 10)
              | (r[5] ? 32'h0 : 32'h4000), r[6], r[7]);
      if (r[8]) idle();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule